// File: doc/BRIEF.md
# Chip-Select Conversion Sequencer with Power-Down

This block sits on the host side of a 12-bit serial converter that runs in its externally clocked mode. A falling chip select puts the converter's sampler into hold and starts a conversion, and the serial clock driven by this block steps it through the conversion. A full cycle is 16 serial-clock falling edges and returns a 16-bit word: four zero bits, then the 12-bit code with its most significant bit first. Each bit is taken just before the falling edge that advances the converter's data line.

The converter has no power pin to control. Its power state follows from how many falling clock edges it sees before chip select rises. This block produces those counts on command. A sleep command runs a short 8-edge burst and raises chip select, which powers the converter down. A wake command holds chip select low for at least 11 falling edges and for at least the converter's power-up time, which makes a dummy cycle whose data is thrown away. The block keeps its own copy of the power state, turns away conversion requests while the converter sleeps, and keeps chip select high for a minimum quiet time between cycles.

Commands come in as a two-bit code with a valid strobe and are taken only while the block is idle. Each finished conversion produces a 12-bit result with a one-cycle valid strobe.

Top module: `adc_cs_sequencer`

## Requirements
- R1: While reset is high, the next clock edge sets chip select high, serial clock high, result_valid low, asleep low and cmd_ready high.
- R2: Command code 2'b01 (convert), taken while awake, drives chip select low for exactly 16 serial-clock falling edges. The result is the 12 data-line values taken just before falling edges 5 to 16, first value as MSB. result_valid is high for exactly one cycle, in the same cycle in which chip select returns high.
- R3: The serial clock stays high whenever chip select is high. Each half period is SCLK_HALF clock cycles (136 ns by default, so a 272 ns period, below 3.7 MHz). The first falling edge comes SCLK_HALF cycles after chip select falls.
- R4: Command code 2'b10 (sleep) drives exactly 8 falling edges and then raises chip select. It sets asleep and gives no result_valid.
- R5: A convert command that arrives while asleep is high is taken and dropped. Chip select never goes low and asleep stays high.
- R6: Command code 2'b11 (wake) holds chip select low until at least 11 falling edges have passed and at least WAKE_NS (4330 ns) has passed since chip select fell. It then clears asleep and gives no result_valid.
- R7: After every cycle, chip select stays high for at least QUIET_NS (100 ns) before the next falling edge. cmd_ready is low from the start of a cycle until the quiet time ends.
- R8: A convert command issued after a wake cycle returns the converter's real code.
- R9: cmd_valid has no effect while cmd_ready is low, and command code 2'b00 has no effect at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 convert, 10 sleep, 11 wake |
| cmd_ready | output | 1 | High while idle and able to take a command |
| cs_n | output | 1 | Chip select to converter, active low |
| sclk | output | 1 | Serial clock to converter, idles high |
| sdata_in | input | 1 | Serial data from converter |
| result | output | 12 | Last conversion code |
| result_valid | output | 1 | One-cycle strobe for a new result |
| asleep | output | 1 | Tracked converter power state |

## Verification
An edge counter that is off by one shows at the ports within one cycle of chip select rising. The burst is then too long or too short as seen by the converter model, and a result comes back shifted by one bit. A stale power-state bit shows on the next command: a conversion after wake is refused, or one during sleep runs and returns all ones. A wrong quiet or wake timer shows as a shorter chip-select high or low interval, which is measured in time from the first affected cycle.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_CONVERT = 2'b01,
    OP_SLEEP   = 2'b10,
    OP_WAKE    = 2'b11
  } seq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_QUIET
  } seq_state_e;
endpackage

// File: rtl/adc_seq_clkdiv.sv
`timescale 1ns/1ps
// Half-period tick generator for the serial clock.
module adc_seq_clkdiv #(
  parameter int HALF = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int W = $clog2(HALF + 1);
  localparam logic [W-1:0] LAST = W'(HALF - 1);

  logic [W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
// Saturating elapsed-cycle counter; met goes high LIMIT cycles after clear drops.
module adc_seq_timer #(
  parameter int LIMIT = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic met
);
  localparam int W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  assign met = (cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_shift.sv
`timescale 1ns/1ps
// Serial capture and result register; leading bits fall off the top.
module adc_seq_shift #(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture,
  input  logic                 bit_in,
  input  logic                 load,
  output logic [DATA_BITS-1:0] result,
  output logic                 result_valid
);
  logic [DATA_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh           <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= load;
      if (capture) sh <= {sh[DATA_BITS-2:0], bit_in};
      if (load)    result <= sh;
    end
  end
endmodule

// File: rtl/adc_cs_sequencer.sv
`timescale 1ns/1ps
module adc_cs_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int SCLK_HALF     = 17,
  parameter int QUIET_NS      = 100,
  parameter int WAKE_NS       = 4330,
  parameter int FRAME_BITS    = 16,
  parameter int DATA_BITS     = 12,
  parameter int SLEEP_FALLS   = 8,
  parameter int WAKE_FALLS    = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  output logic                 cmd_ready,
  output logic                 cs_n,
  output logic                 sclk,
  input  logic                 sdata_in,
  output logic [DATA_BITS-1:0] result,
  output logic                 result_valid,
  output logic                 asleep
);
  localparam int QUIET_CYC = (QUIET_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int WAKE_CYC  = (WAKE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int FW        = $clog2(FRAME_BITS + 1);
  localparam logic [FW-1:0] FRAME_F = FW'(FRAME_BITS);
  localparam logic [FW-1:0] SLEEP_F = FW'(SLEEP_FALLS);
  localparam logic [FW-1:0] WAKE_F  = FW'(WAKE_FALLS);

  seq_state_e    state;
  seq_op_e       cur_op;
  seq_op_e       req_op;
  logic [FW-1:0] falls;
  logic          active, quieting;
  logic          tick, wake_met, quiet_met;
  logic          start, done_cond, finish, capture, load;

  assign req_op    = seq_op_e'(cmd_op);
  assign active    = (state == ST_ACTIVE);
  assign quieting  = (state == ST_QUIET);
  assign cmd_ready = (state == ST_IDLE);

  assign start = cmd_ready && cmd_valid &&
                 ((req_op == OP_SLEEP) || (req_op == OP_WAKE) ||
                  ((req_op == OP_CONVERT) && !asleep));

  always_comb begin
    case (cur_op)
      OP_CONVERT: done_cond = (falls == FRAME_F);
      OP_SLEEP:   done_cond = (falls == SLEEP_F);
      OP_WAKE:    done_cond = (falls >= WAKE_F) && wake_met;
      default:    done_cond = 1'b1;
    endcase
  end

  // End a cycle only with the clock low, or once the frame is used up.
  assign finish  = active && tick && done_cond && (!sclk || (falls == FRAME_F));
  assign capture = active && tick && sclk && (falls != FRAME_F) && !finish;
  assign load    = finish && (cur_op == OP_CONVERT);

  adc_seq_clkdiv #(.HALF(SCLK_HALF)) u_div (
    .clk(clk), .rst(rst), .run(active), .tick(tick)
  );

  adc_seq_timer #(.LIMIT(WAKE_CYC - 1)) u_wake_tmr (
    .clk(clk), .rst(rst), .clear(!active), .met(wake_met)
  );

  adc_seq_timer #(.LIMIT(QUIET_CYC - 1)) u_quiet_tmr (
    .clk(clk), .rst(rst), .clear(!quieting), .met(quiet_met)
  );

  adc_seq_shift #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst(rst), .capture(capture), .bit_in(sdata_in),
    .load(load), .result(result), .result_valid(result_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cur_op <= OP_NONE;
      falls  <= '0;
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
      asleep <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cur_op <= req_op;
            falls  <= '0;
            cs_n   <= 1'b0;
            state  <= ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (finish) begin
            cs_n  <= 1'b1;
            sclk  <= 1'b1;
            state <= ST_QUIET;
            if (cur_op == OP_SLEEP)     asleep <= 1'b1;
            else if (cur_op == OP_WAKE) asleep <= 1'b0;
          end else if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else if (falls != FRAME_F) begin
              sclk  <= 1'b0;
              falls <= falls + 1'b1;
            end
          end
        end
        ST_QUIET: begin
          if (quiet_met) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_checker.sv
`timescale 1ns/1ps
module adc_seq_checker
  import adc_seq_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int SLEEP_FALLS = 8,
  parameter int WAKE_FALLS  = 11,
  parameter int QUIET_CYC   = 13,
  parameter int WAKE_CYC    = 542
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_ready,
  input logic       cs_n,
  input logic       sclk,
  input logic       result_valid,
  input logic       asleep
);
  int   fc, lo_cnt, hi_cnt;
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fc     <= 0;
      lo_cnt <= 0;
      hi_cnt <= QUIET_CYC;
      sclk_q <= 1'b1;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        fc     <= 0;
        lo_cnt <= 0;
        if (hi_cnt < QUIET_CYC) hi_cnt <= hi_cnt + 1;
      end else begin
        hi_cnt <= 0;
        lo_cnt <= lo_cnt + 1;
        if (sclk_q && !sclk) fc <= fc + 1;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cs_n && sclk && cmd_ready && !result_valid && !asleep));

  assert_full_frame_R2: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> ($rose(cs_n) && fc == FRAME_BITS));

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  assert_sleep_burst_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> ($rose(cs_n) && fc == SLEEP_FALLS && !result_valid));

  assert_reject_asleep_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && cmd_valid && cmd_op == OP_CONVERT && asleep) |=> (cs_n && cmd_ready));

  assert_wake_window_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> ($rose(cs_n) && fc >= WAKE_FALLS && lo_cnt >= WAKE_CYC && !result_valid));

  assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= QUIET_CYC));

  assert_busy_ready_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !cmd_ready);
endmodule

bind adc_cs_sequencer adc_seq_checker #(
  .FRAME_BITS(FRAME_BITS), .SLEEP_FALLS(SLEEP_FALLS), .WAKE_FALLS(WAKE_FALLS),
  .QUIET_CYC(QUIET_CYC), .WAKE_CYC(WAKE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .cs_n(cs_n), .sclk(sclk),
  .result_valid(result_valid), .asleep(asleep)
);

// File: tb/adc_cs_sequencer_test.sv
`timescale 1ns/1ps
module adc_cs_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic        cmd_ready, cs_n, sclk, result_valid, asleep;
  logic        m_sdata = 1'b0;
  logic [11:0] result;

  always #4 clk = ~clk;

  adc_cs_sequencer uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .cs_n(cs_n), .sclk(sclk), .sdata_in(m_sdata),
    .result(result), .result_valid(result_valid), .asleep(asleep)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // Converter model: power state from edge count at chip-select rise.
  logic [11:0] m_code = 12'h000;
  logic [15:0] m_frame;
  bit          m_asleep = 0;
  int          m_falls = 0, last_falls = 0, cs_falls = 0;
  realtime     t_cs_fall = 0, t_cs_rise = 0, t_sclk_fall = 0, last_low = 0;
  realtime     min_quiet = 1.0e9, min_period = 1.0e9, min_first = 1.0e9;

  always @(negedge cs_n) begin
    if (cs_falls > 0 && ($realtime - t_cs_rise) < min_quiet) min_quiet = $realtime - t_cs_rise;
    cs_falls++;
    t_cs_fall = $realtime;
    m_falls   = 0;
    m_frame   = m_asleep ? 16'hFFFF : {4'b0000, m_code};
    m_sdata  <= #2 m_frame[15];
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      if (m_falls == 0) begin
        if (($realtime - t_cs_fall) < min_first) min_first = $realtime - t_cs_fall;
      end else if (($realtime - t_sclk_fall) < min_period) begin
        min_period = $realtime - t_sclk_fall;
      end
      t_sclk_fall = $realtime;
      m_falls++;
      m_sdata <= #2 (m_falls < 16) ? m_frame[15 - m_falls] : 1'b0;
    end
  end

  always @(posedge cs_n) begin
    if (cs_falls > 0) begin
      t_cs_rise  = $realtime;
      last_low   = $realtime - t_cs_fall;
      last_falls = m_falls;
      if (m_asleep) begin
        if (m_falls >= 11) m_asleep = 0;
      end else if (m_falls >= 2 && m_falls <= 10) begin
        m_asleep = 1;
      end
    end
  end

  int          vcount = 0;
  logic [11:0] vres = '0;
  always @(negedge clk) begin
    if (result_valid) begin
      vcount++;
      vres = result;
    end
  end

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'b00;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (!cmd_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // {op[1:0], code[11:0], exp_valid, exp_asleep, exp_falls[4:0]}
  localparam logic [20:0] VEC [10] = '{
    {2'b01, 12'h5A3, 1'b1, 1'b0, 5'd16},  // R2
    {2'b01, 12'h800, 1'b1, 1'b0, 5'd16},  // R2 sign bit
    {2'b10, 12'h000, 1'b0, 1'b1, 5'd8},   // R4
    {2'b01, 12'h123, 1'b0, 1'b1, 5'd0},   // R5 rejected
    {2'b11, 12'h000, 1'b0, 1'b0, 5'd16},  // R6
    {2'b01, 12'h7FF, 1'b1, 1'b0, 5'd16},  // R8
    {2'b01, 12'h001, 1'b1, 1'b0, 5'd16},  // R2 lsb
    {2'b10, 12'h000, 1'b0, 1'b1, 5'd8},   // R4
    {2'b11, 12'h000, 1'b0, 1'b0, 5'd16},  // R6
    {2'b01, 12'hABC, 1'b1, 1'b0, 5'd16}   // R8
  };

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b1, "R1 reset pins", {cs_n, sclk}, 3);
    check(cmd_ready && !result_valid && !asleep, "R1 reset status",
          {cmd_ready, result_valid, asleep}, 4);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    foreach (VEC[i]) begin
      logic [1:0]  op;
      logic [11:0] code;
      logic        ev, es;
      int          ef, v0, c0;
      string       tag;
      {op, code, ev, es, ef} = {VEC[i][20:19], VEC[i][18:7], VEC[i][6], VEC[i][5], int'(VEC[i][4:0])};
      tag = (op == 2'b10) ? "R4" : (op == 2'b11) ? "R6" : (ef == 0) ? "R5" :
            (i >= 5) ? "R8" : "R2";
      m_code = code;
      v0 = vcount;
      c0 = cs_falls;
      issue(op);
      wait_idle();
      check(vcount - v0 == int'(ev), {tag, " result strobes"}, vcount - v0, int'(ev));
      if (ev) check(vres == code, {tag, " result code"}, vres, code);
      check(asleep == es, {tag, " asleep"}, asleep, es);
      check(m_asleep == asleep, {tag, " model power agrees"}, m_asleep, asleep);
      if (ef == 0) begin
        check(cs_falls == c0, {tag, " no chip select"}, cs_falls - c0, 0);
      end else begin
        check(cs_falls == c0 + 1, {tag, " one cycle"}, cs_falls - c0, 1);
        check(last_falls == ef, {tag, " falling edges"}, last_falls, ef);
      end
      if (op == 2'b11) check(last_low >= 4330.0, "R6 wake low time ns", int'(last_low), 4330);
    end

    // R9: command during a busy cycle has no effect
    begin
      int v0, c0;
      m_code = 12'h3C5;
      v0 = vcount;
      c0 = cs_falls;
      issue(2'b01);
      repeat (100) @(negedge clk);
      check(!cmd_ready, "R9 ready low while busy", cmd_ready, 0);
      cmd_valid = 1'b1; cmd_op = 2'b10;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      wait_idle();
      repeat (20) @(negedge clk);
      check(cs_falls == c0 + 1, "R9 busy command no extra cycle", cs_falls - c0, 1);
      check(!asleep, "R9 busy sleep ignored", asleep, 0);
      check(vcount == v0 + 1 && vres == 12'h3C5, "R9 busy convert intact", vres, 12'h3C5);
    end

    // R9: command code 00 does nothing
    begin
      int c0;
      c0 = cs_falls;
      issue(2'b00);
      repeat (50) @(negedge clk);
      check(cs_falls == c0 && cmd_ready, "R9 null command", cs_falls - c0, 0);
    end

    check(min_period >= 271.0 && min_period <= 273.0, "R3 sclk period ns", int'(min_period), 272);
    check(min_first >= 135.0 && min_first <= 137.0, "R3 first fall ns", int'(min_first), 136);
    check(min_quiet >= 100.0, "R7 quiet gap ns", int'(min_quiet), 100);

    // R1: reset in the middle of a wake cycle while asleep
    issue(2'b10);
    wait_idle();
    check(asleep, "R4 asleep before reset test", asleep, 1);
    issue(2'b11);
    repeat (200) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && sclk && cmd_ready, "R1 mid-cycle reset pins", {cs_n, sclk, cmd_ready}, 7);
    check(!asleep && !result_valid, "R1 mid-cycle reset status", {asleep, result_valid}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule